// File: doc/BRIEF.md
# Register-Mapped Signed Integer Divider

The block is a small signed integer divide engine that a processor drives through a plain register bus. Software places a numerator and a denominator, each 64 bits wide and split into a low and a high 32-bit word, then writes a control word that picks one of three operand widths. Every write to an operand word or to the control word launches a fresh division. The engine then works for a fixed number of cycles, with a busy bit visible in the control word, and finally posts a 64-bit quotient and a 64-bit remainder. These can be read back as word pairs.

Two results that plain arithmetic leaves undefined get exact, fixed answers here. A zero divisor sets a status bit and returns a fixed quotient with the numerator as remainder. The most negative numerator divided by minus one also sets that bit and returns the numerator as the quotient. Software polls the busy bit and then reads the results. It never stalls the bus.

Top module: `mmio_divider`

## Requirements
- R1: After reset every register index (0 to 8) reads as zero, so busy (control bit 15) and the zero-divisor bit (control bit 14) are both clear.
- R2: Register indices are: 0 control, 1/2 numerator low/high, 3/4 denominator low/high, 5/6 quotient low/high, 7/8 remainder low/high. The low word holds bits 31:0 and the high word bits 63:32. Operand words read back as written.
- R3: A write to index 0 to 4 starts a division. Control bit 15 reads 1 from the cycle after that write until results are posted.
- R4: With control bits 1:0 equal to 0, results post and bit 15 clears 18 clock edges after the starting write edge. For modes 1, 2 and 3 this takes 34 edges.
- R5: Mode 0 divides the sign-extended low numerator word by the sign-extended low denominator word. Modes 1 and 3 divide the full 64-bit numerator by the sign-extended low denominator word. Mode 2 divides the full 64-bit numerator by the full 64-bit denominator. Unused high words have no effect.
- R6: The quotient is truncated toward zero. The remainder carries the numerator's sign and satisfies numerator = quotient*denominator + remainder.
- R7: When the effective denominator is zero, bit 14 is set and the remainder equals the effective numerator. The quotient is 1 for a negative numerator and 0 otherwise.
- R8: When the effective numerator is the most negative value of its width (32 bits in mode 0, 64 otherwise) and the effective denominator is -1, the quotient equals the sign-extended numerator, the remainder is 0 and bit 14 is set.
- R9: A division that hits neither R7 nor R8 clears bit 14 when it posts.
- R10: A write to index 0 to 4 while busy restarts the division. The latency counts from the newest write, and the results use the updated operands.
- R11: Writes to indices 5 to 8 are ignored and start nothing. On a control write only bits 1:0 are stored, and all other bits except 15 and 14 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_idx | input | 4 | Register index written |
| wr_data | input | 32 | Write data |
| rd_idx | input | 4 | Register index read |
| rd_data | output | 32 | Read data, combinational from rd_idx |

## Verification
Reads are combinational, so the operand read-back and the control word right after a write are checked at the falling edge that follows that write. The busy bit is due high at that same point. The quotient, remainder, zero-divisor bit and busy clear are due 18 rising edges after the starting write in mode 0 and 34 edges in the other modes. Each division scenario therefore samples the busy bit at the falling edge just before that edge, where it must still be set, and everything else at the falling edge just after it. The restart scenario counts the window from the last write only.

// File: rtl/divu_pkg.sv
// Package: shared constants and types for the register-mapped divider.
// Assumes 32-bit bus words and 64-bit operands; index values are the bus map.
package divu_pkg;
    localparam int WORD_W = 32;
    localparam int OPND_W = 64;
    localparam int IDX_W  = 4;

    localparam logic [IDX_W-1:0] IDX_CTRL   = 4'd0;
    localparam logic [IDX_W-1:0] IDX_NUM_LO = 4'd1;
    localparam logic [IDX_W-1:0] IDX_NUM_HI = 4'd2;
    localparam logic [IDX_W-1:0] IDX_DEN_LO = 4'd3;
    localparam logic [IDX_W-1:0] IDX_DEN_HI = 4'd4;
    localparam logic [IDX_W-1:0] IDX_QUO_LO = 4'd5;
    localparam logic [IDX_W-1:0] IDX_QUO_HI = 4'd6;
    localparam logic [IDX_W-1:0] IDX_REM_LO = 4'd7;
    localparam logic [IDX_W-1:0] IDX_REM_HI = 4'd8;

    localparam int BUSY_BIT = 15;
    localparam int ZDIV_BIT = 14;

    // Conditioned operands handed from the prep stage to the engine.
    typedef struct packed {
        logic [OPND_W-1:0] eff_num;
        logic [OPND_W-1:0] nmag;
        logic [OPND_W-1:0] dmag;
        logic              q_neg;
        logic              r_neg;
        logic              zero_den;
        logic              ovf;
        logic              narrow;
    } prep_t;

    typedef enum logic [1:0] {ST_IDLE, ST_PREP, ST_RUN, ST_DONE} eng_state_e;
endpackage

// File: rtl/divu_regfile.sv
// Module: operand and mode storage for the divider.
// Holds the 2-bit mode and both 64-bit operands as word pairs and raises a
// start pulse for writes to the control or operand indices. Assumes at most
// one write per cycle; result indices are not stored here.
module divu_regfile
    import divu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    output logic [1:0]        mode_o,
    output logic [OPND_W-1:0] num_o,
    output logic [OPND_W-1:0] den_o,
    output logic              start_o
);
    logic [1:0]        mode_q;
    logic [OPND_W-1:0] num_q;
    logic [OPND_W-1:0] den_q;

    // Start is any write at or below the top operand index.
    assign start_o = wr_en && (wr_idx <= IDX_DEN_HI);

    // Register writes, low word at bits 31:0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            num_q  <= '0;
            den_q  <= '0;
        end else if (wr_en) begin
            case (wr_idx)
                IDX_CTRL:   mode_q              <= wr_data[1:0];
                IDX_NUM_LO: num_q[WORD_W-1:0]   <= wr_data;
                IDX_NUM_HI: num_q[OPND_W-1:WORD_W] <= wr_data;
                IDX_DEN_LO: den_q[WORD_W-1:0]   <= wr_data;
                IDX_DEN_HI: den_q[OPND_W-1:WORD_W] <= wr_data;
                default: ;
            endcase
        end
    end

    assign mode_o = mode_q;
    assign num_o  = num_q;
    assign den_o  = den_q;

    // R2
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> ($stable(num_q) && $stable(den_q) && $stable(mode_q)));
endmodule

// File: rtl/divu_prep.sv
// Module: combinational operand conditioning.
// Narrows and sign-extends the operands per mode, takes magnitudes and
// detects the zero-divisor and overflow cases. Assumes mode 0 is 32/32,
// mode 2 is 64/64 and modes 1 and 3 are 64/32.
module divu_prep
    import divu_pkg::*;
(
    input  logic [1:0]        mode_i,
    input  logic [OPND_W-1:0] num_i,
    input  logic [OPND_W-1:0] den_i,
    output prep_t             prep_o
);
    localparam logic [OPND_W-1:0] MIN32_SX = {{(OPND_W-WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};
    localparam logic [OPND_W-1:0] MIN64    = {1'b1, {(OPND_W-1){1'b0}}};

    logic [OPND_W-1:0] eff_num, eff_den;
    logic              narrow, wide_den, nneg, dneg;

    // Operand width selection with sign extension.
    always_comb begin
        narrow   = (mode_i == 2'd0);
        wide_den = (mode_i == 2'd2);
        eff_num  = narrow ? {{(OPND_W-WORD_W){num_i[WORD_W-1]}}, num_i[WORD_W-1:0]} : num_i;
        eff_den  = wide_den ? den_i : {{(OPND_W-WORD_W){den_i[WORD_W-1]}}, den_i[WORD_W-1:0]};
        nneg     = eff_num[OPND_W-1];
        dneg     = eff_den[OPND_W-1];
    end

    // Magnitudes, signs and special-case flags.
    always_comb begin
        prep_o.eff_num  = eff_num;
        prep_o.nmag     = nneg ? (~eff_num + 1'b1) : eff_num;
        prep_o.dmag     = dneg ? (~eff_den + 1'b1) : eff_den;
        prep_o.q_neg    = nneg ^ dneg;
        prep_o.r_neg    = nneg;
        prep_o.zero_den = (eff_den == '0);
        prep_o.ovf      = (eff_den == '1) &&
                          (narrow ? (eff_num == MIN32_SX) : (eff_num == MIN64));
        prep_o.narrow   = narrow;
    end
endmodule

// File: rtl/divu_engine.sv
// Module: iterative restoring divide engine with sequencer and result store.
// One prep cycle, then STEP_BITS quotient bits per cycle (32 bits in the
// narrow mode, 64 otherwise), then one finish cycle that applies signs and
// special cases. A start pulse in any state restarts from the prep cycle.
module divu_engine
    import divu_pkg::*;
#(
    parameter int STEP_BITS = 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  prep_t             prep_i,
    output logic              busy_o,
    output logic              zdiv_o,
    output logic [OPND_W-1:0] quo_o,
    output logic [OPND_W-1:0] rem_o
);
    localparam int STEPS_N = WORD_W / STEP_BITS;
    localparam int STEPS_W = OPND_W / STEP_BITS;
    localparam int CNT_W   = $clog2(STEPS_W + 1);
    localparam int REM_W   = OPND_W + 1;

    eng_state_e        state_q;
    logic              busy_q, zdiv_q;
    logic [CNT_W-1:0]  cnt_q;
    prep_t             p_q;
    logic [REM_W-1:0]  r_q;
    logic [OPND_W-1:0] q_q;
    logic [OPND_W-1:0] quo_q, rem_q;

    logic [REM_W-1:0]  r_chain [STEP_BITS+1];
    logic [OPND_W-1:0] q_chain [STEP_BITS+1];

    assign r_chain[0] = r_q;
    assign q_chain[0] = q_q;

    // Chain of restoring steps, one quotient bit per stage.
    for (genvar g = 0; g < STEP_BITS; g++) begin : g_step
        logic [REM_W-1:0] shifted;
        logic [REM_W:0]   diff;
        assign shifted = {r_chain[g][OPND_W-1:0], q_chain[g][OPND_W-1]};
        assign diff    = {1'b0, shifted} - {2'b00, p_q.dmag};
        assign r_chain[g+1] = diff[REM_W] ? shifted : diff[REM_W-1:0];
        assign q_chain[g+1] = {q_chain[g][OPND_W-2:0], ~diff[REM_W]};
    end

    // Sequencer, working registers and result posting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
            zdiv_q  <= 1'b0;
            cnt_q   <= '0;
            p_q     <= '0;
            r_q     <= '0;
            q_q     <= '0;
            quo_q   <= '0;
            rem_q   <= '0;
        end else if (start_i) begin
            state_q <= ST_PREP;
            busy_q  <= 1'b1;
        end else begin
            case (state_q)
                ST_PREP: begin
                    p_q     <= prep_i;
                    r_q     <= '0;
                    q_q     <= prep_i.narrow ? {prep_i.nmag[WORD_W-1:0], {WORD_W{1'b0}}} : prep_i.nmag;
                    cnt_q   <= prep_i.narrow ? CNT_W'(STEPS_N) : CNT_W'(STEPS_W);
                    state_q <= ST_RUN;
                end
                ST_RUN: begin
                    r_q   <= r_chain[STEP_BITS];
                    q_q   <= q_chain[STEP_BITS];
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) state_q <= ST_DONE;
                end
                ST_DONE: begin
                    if (p_q.zero_den) begin
                        quo_q  <= {{(OPND_W-1){1'b0}}, p_q.eff_num[OPND_W-1]};
                        rem_q  <= p_q.eff_num;
                        zdiv_q <= 1'b1;
                    end else if (p_q.ovf) begin
                        quo_q  <= p_q.eff_num;
                        rem_q  <= '0;
                        zdiv_q <= 1'b1;
                    end else begin
                        quo_q  <= p_q.q_neg ? (~q_q + 1'b1) : q_q;
                        rem_q  <= p_q.r_neg ? (~r_q[OPND_W-1:0] + 1'b1) : r_q[OPND_W-1:0];
                        zdiv_q <= 1'b0;
                    end
                    busy_q  <= 1'b0;
                    state_q <= ST_IDLE;
                end
                default: ;
            endcase
        end
    end

    assign busy_o = busy_q;
    assign zdiv_o = zdiv_q;
    assign quo_o  = quo_q;
    assign rem_o  = rem_q;

    // R3
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_q);
    // R4
    busy_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !start_i) |=> !busy_q);
    // R4
    step_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(STEPS_W));
    // R9
    zdiv_only_at_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_DONE) |=> $stable(zdiv_q));
    // R11
    results_only_at_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_DONE) |=> ($stable(quo_q) && $stable(rem_q)));
endmodule

// File: rtl/mmio_divider.sv
// Module: top of the register-mapped signed divider.
// Ties the register file, operand prep and engine together and provides the
// combinational read mux. Assumes one bus write per cycle; reads have no
// side effects.
module mmio_divider
    import divu_pkg::*;
#(
    parameter int STEP_BITS = 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    logic [1:0]        mode;
    logic [OPND_W-1:0] num, den, quo, rem;
    logic              start, busy, zdiv;
    prep_t             prep;

    divu_regfile i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .mode_o(mode), .num_o(num), .den_o(den),
        .start_o(start)
    );

    divu_prep i_prep (
        .mode_i(mode), .num_i(num), .den_i(den), .prep_o(prep)
    );

    divu_engine #(.STEP_BITS(STEP_BITS)) i_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start), .prep_i(prep),
        .busy_o(busy), .zdiv_o(zdiv), .quo_o(quo), .rem_o(rem)
    );

    // Read mux over the register map.
    always_comb begin
        rd_data = '0;
        case (rd_idx)
            IDX_CTRL: begin
                rd_data[1:0]     = mode;
                rd_data[ZDIV_BIT] = zdiv;
                rd_data[BUSY_BIT] = busy;
            end
            IDX_NUM_LO: rd_data = num[WORD_W-1:0];
            IDX_NUM_HI: rd_data = num[OPND_W-1:WORD_W];
            IDX_DEN_LO: rd_data = den[WORD_W-1:0];
            IDX_DEN_HI: rd_data = den[OPND_W-1:WORD_W];
            IDX_QUO_LO: rd_data = quo[WORD_W-1:0];
            IDX_QUO_HI: rd_data = quo[OPND_W-1:WORD_W];
            IDX_REM_LO: rd_data = rem[WORD_W-1:0];
            IDX_REM_HI: rd_data = rem[OPND_W-1:WORD_W];
            default: ;
        endcase
    end

    // R11
    result_write_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= IDX_QUO_LO && !busy) |=> !busy);
endmodule

// File: tb/test_mmio_divider.sv
// Directed bench for the register-mapped divider: one task per scenario.
module test_mmio_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    mmio_divider i_mmio_divider (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One-cycle write; returns at the falling edge after the write edge.
    task automatic wr(input logic [3:0] idx, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = data;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] data);
        rd_idx = idx;
        #1;
        data = rd_data;
    endtask

    task automatic rd64(input logic [3:0] lo, output logic [63:0] data);
        logic [31:0] a, b;
        rd(lo, a);
        rd(lo + 4'd1, b);
        data = {b, a};
    endtask

    function automatic void model(input logic [1:0] m, input logic [63:0] n, d,
                                  output logic [63:0] q, r, output logic f);
        logic signed [63:0] en, ed;
        en = (m == 2'd0) ? {{32{n[31]}}, n[31:0]} : n;
        ed = (m == 2'd2) ? d : {{32{d[31]}}, d[31:0]};
        if (ed == 0) begin
            q = en[63] ? 64'd1 : 64'd0; r = en; f = 1'b1;
        end else if (ed == -1 && ((m == 2'd0 && en == 64'hFFFF_FFFF_8000_0000) ||
                                  (m != 2'd0 && en == 64'h8000_0000_0000_0000))) begin
            q = en; r = 64'd0; f = 1'b1;
        end else begin
            q = en / ed; r = en % ed; f = 1'b0;
        end
    endfunction

    // Check busy and results on the cycle each is due after the last write.
    task automatic await_and_check(input string req, input logic [1:0] m,
                                   input logic [63:0] n, d);
        logic [31:0] c;
        logic [63:0] q, r, eq, er;
        logic        ef;
        int lat;
        lat = (m == 2'd0) ? 18 : 34;
        model(m, n, d, eq, er, ef);
        repeat (lat - 1) @(negedge clk);
        rd(4'd0, c);
        check("R3", {req, " busy before due edge"}, 64'(c[15]), 64'd1);
        @(negedge clk);
        rd(4'd0, c);
        check("R4", {req, " busy after due edge"}, 64'(c[15]), 64'd0);
        rd64(4'd5, q);
        rd64(4'd7, r);
        check(req, "quotient", q, eq);
        check(req, "remainder", r, er);
        check(req, "zero-divisor bit", 64'(c[14]), 64'(ef));
    endtask

    task automatic run_div(input string req, input logic [1:0] m,
                           input logic [63:0] n, d);
        wr(4'd1, n[31:0]);
        wr(4'd2, n[63:32]);
        wr(4'd3, d[31:0]);
        wr(4'd4, d[63:32]);
        wr(4'd0, {30'd0, m});
        await_and_check(req, m, n, d);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int i = 0; i < 9; i++) begin
            rd(4'(i), v);
            check("R1", $sformatf("reset index %0d", i), 64'(v), 64'd0);
        end
    endtask

    task automatic t_regmap;
        logic [63:0] v;
        wr(4'd1, 32'h1122_3344);
        wr(4'd2, 32'h5566_7788);
        wr(4'd3, 32'h99AA_BBCC);
        wr(4'd4, 32'hDDEE_FF00);
        rd64(4'd1, v);
        check("R2", "numerator word pair", v, 64'h5566_7788_1122_3344);
        rd64(4'd3, v);
        check("R2", "denominator word pair", v, 64'hDDEE_FF00_99AA_BBCC);
        repeat (40) @(negedge clk);
    endtask

    task automatic t_restart;
        wr(4'd1, 32'd1000);
        wr(4'd2, 32'd0);
        wr(4'd3, 32'd10);
        wr(4'd4, 32'd0);
        wr(4'd0, 32'd2);
        repeat (5) @(negedge clk);
        wr(4'd1, 32'd777);
        await_and_check("R10", 2'd2, 64'd777, 64'd10);
    endtask

    task automatic t_ignored;
        logic [31:0] c;
        logic [63:0] q0, q1;
        rd64(4'd5, q0);
        wr(4'd5, 32'hCAFE_F00D);
        rd(4'd0, c);
        check("R11", "result write starts nothing", 64'(c[15]), 64'd0);
        rd64(4'd5, q1);
        check("R11", "quotient unchanged by write", q1, q0);
        wr(4'd8, 32'h1234_5678);
        rd64(4'd5, q1);
        check("R11", "quotient unchanged by remainder write", q1, q0);
        wr(4'd1, 32'd50);
        wr(4'd2, 32'd0);
        wr(4'd3, 32'd5);
        wr(4'd0, 32'hFFFF_3FFD);
        rd(4'd0, c);
        check("R11", "control reserved bits", 64'(c & 32'hFFFF_3FFF), 64'd1);
        await_and_check("R11", 2'd1, 64'd50, 64'h0000_0000_0000_0005);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        run_div("R5", 2'd0, 64'hDEAD_BEEF_0000_0064, 64'hBEEF_DEAD_0000_0007);
        run_div("R6", 2'd0, 64'h0000_0000_FFFF_FF9C, 64'd7);
        run_div("R6", 2'd0, 64'd100, 64'h0000_0000_FFFF_FFF9);
        run_div("R6", 2'd0, 64'hFFFF_FF9C, 64'hFFFF_FFF9);
        run_div("R5", 2'd1, 64'h0000_0123_4567_89AB, 64'h7777_7777_0000_1000);
        run_div("R5", 2'd3, 64'hFFFF_F000_0000_0123, 64'h0000_0001_FFFF_FFF0);
        run_div("R5", 2'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0003);
        run_div("R6", 2'd2, 64'hFFFF_FFFF_FFFF_FFFB, 64'h8000_0000_0000_0000);
        run_div("R7", 2'd0, 64'h0000_0000_FFFF_FFF9, 64'h1111_1111_0000_0000);
        run_div("R9", 2'd0, 64'd9, 64'd4);
        run_div("R7", 2'd2, 64'h0000_0042_0000_0001, 64'd0);
        run_div("R8", 2'd0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF);
        run_div("R8", 2'd2, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
        run_div("R8", 2'd1, 64'h8000_0000_0000_0000, 64'h0000_0000_FFFF_FFFF);
        run_div("R9", 2'd1, 64'h8000_0000_0000_0000, 64'd3);
        t_restart();
        t_ignored();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule